// File: doc/BRIEF.md
# Wide Integer Add/Subtract Execution Unit

This unit is the add/subtract/compare slice of the integer execute stage in a core whose registers are 128 bits wide. Each cycle it can accept one 32-bit instruction word and two register operands. Each operand arrives as a low 64-bit half and a high 64-bit half. It decodes the instruction and produces a 128-bit result, the destination register index and a write enable. All outputs are registered, so they appear one clock after the request.

Each instruction selects one of three operation lengths: 32, 64 or 128 bits. The 128-bit datapath is built from two 64-bit adder slices joined by a carry chain. Results shorter than 128 bits are sign-extended to the full register width. A mode input selects between 128-bit operation and 64-bit operation. In 64-bit mode the full-width instructions act at 64-bit length, and the explicit 64-bit-length instructions are refused.

Top module: `rv_wide_addsub_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `res_valid`, `res_we` and `res_illegal` are cleared, even when `in_valid` is high.
- R2: The outputs for a request presented with `in_valid` high appear after the next rising clock edge. `res_valid` equals `in_valid` delayed by one cycle, and `res_rd` carries instruction bits [11:7].
- R3: With `wide_mode`=1, opcode 0110011 with funct3 (bits [14:12]) 000 adds (funct7, bits [31:25], = 0000000) or subtracts (funct7 = 0100000) across all 128 bits. The carry or borrow passes from bit 63 into bit 64.
- R4: Opcode 0010011 with funct3 000 adds the 12-bit immediate in bits [31:20]. The immediate is sign-extended to 128 bits, so a negative immediate contributes an all-ones high half.
- R5: Signed compare (funct3 010) and unsigned compare (funct3 011) exist under opcode 0110011 (funct7 0000000) and under opcode 0010011, where the second operand is the sign-extended immediate. They return 1 in bit 0 when the first operand is less than the second. Bits [127:1] are always zero.
- R6: Opcodes 0111011 (funct3 000, funct7 0000000 add / 0100000 subtract) and 0011011 (funct3 000, immediate add) operate on bits [31:0] only. The 32-bit result is sign-extended from bit 31. They are legal in both modes.
- R7: Opcodes 1111011 (funct3 000, funct7 0000000 add / 0100000 subtract) and 1011011 (funct3 000, immediate add) operate on bits [63:0] only. The result is sign-extended from bit 63. These opcodes are legal only when `wide_mode`=1.
- R8: With `wide_mode`=0, the full-width add, subtract and immediate add act at 64-bit length, with the result sign-extended from bit 63. The compares use only the low halves.
- R9: Any encoding not listed in R3 to R7, and any R7 encoding presented when `wide_mode`=0, sets `res_illegal`. For such a request `res_we` is 0 and `res_data` is 0.
- R10: A legal request whose destination field is 0 produces `res_we`=0. `res_valid` is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| instr | input | 32 | Instruction word |
| wide_mode | input | 1 | 1 = 128-bit mode, 0 = 64-bit mode |
| src1_lo | input | 64 | First operand, bits [63:0] |
| src1_hi | input | 64 | First operand, bits [127:64] |
| src2_lo | input | 64 | Second operand, bits [63:0] |
| src2_hi | input | 64 | Second operand, bits [127:64] |
| res_valid | output | 1 | Result present |
| res_data | output | 128 | Result value |
| res_rd | output | 5 | Destination register index |
| res_we | output | 1 | Register write enable |
| res_illegal | output | 1 | Request was not a recognised encoding |

## Verification
The bench targets the points where a split-halves datapath tends to break:
- Carry into the high half, and borrow out of the low half. A broken link between the slices leaves the upper 64 bits unchanged.
- A negative immediate. If it is extended only to 64 bits, the high half comes out wrong.
- Compares whose answer depends only on the high halves. A compare that looks at one half, or that mixes up signed and unsigned treatment, returns the wrong bit.
- Shorter-length results that carry junk in the unused bits. These expose missing sign extension from bit 31 or bit 63.
- The mode input. The 64-bit-length opcodes must be refused in 64-bit mode, and a full add must not carry beyond bit 63 in that mode.
- Unknown encodings and destination zero. A design that writes on either of these would corrupt the register file.

// File: rtl/rv_wide_pkg.sv
package rv_wide_pkg;

    localparam int HALF_W    = 64;
    localparam int N_HALVES  = 2;
    localparam int FULL_W    = HALF_W * N_HALVES;
    localparam int WORD_W    = 32;
    localparam int IMM_W     = 12;
    localparam int REG_IDX_W = 5;
    localparam int INSTR_W   = 32;

    localparam logic [6:0] OPC_REG   = 7'b0110011;
    localparam logic [6:0] OPC_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_REG_W = 7'b0111011;
    localparam logic [6:0] OPC_IMM_W = 7'b0011011;
    localparam logic [6:0] OPC_REG_D = 7'b1111011;
    localparam logic [6:0] OPC_IMM_D = 7'b1011011;

    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;

    localparam logic [2:0] F3_ADD  = 3'b000;
    localparam logic [2:0] F3_SLT  = 3'b010;
    localparam logic [2:0] F3_SLTU = 3'b011;

    typedef enum logic [1:0] {
        LEN32  = 2'd0,
        LEN64  = 2'd1,
        LEN128 = 2'd2
    } op_len_e;

    typedef enum logic [1:0] {
        K_ADD  = 2'd0,
        K_SUB  = 2'd1,
        K_SLT  = 2'd2,
        K_SLTU = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic                 legal;
        op_kind_e             kind;
        op_len_e              len;
        logic                 use_imm;
        logic [IMM_W-1:0]     imm;
        logic [REG_IDX_W-1:0] rd;
    } exec_ctrl_t;

    function automatic logic [FULL_W-1:0] widen_imm(input logic [IMM_W-1:0] imm);
        return {{(FULL_W-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

    function automatic logic [FULL_W-1:0] fit_length(input logic [FULL_W-1:0] v,
                                                     input op_len_e len);
        logic [FULL_W-1:0] r;
        case (len)
            LEN32:   r = {{(FULL_W-WORD_W){v[WORD_W-1]}}, v[WORD_W-1:0]};
            LEN64:   r = {{(FULL_W-HALF_W){v[HALF_W-1]}}, v[HALF_W-1:0]};
            default: r = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rv_wide_decode.sv
module rv_wide_decode
    import rv_wide_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               wide_mode,
    output exec_ctrl_t         ctrl
);

    logic [6:0] opc;
    logic [6:0] f7;
    logic [2:0] f3;
    op_len_e    full_len;

    assign opc      = instr[6:0];
    assign f7       = instr[31:25];
    assign f3       = instr[14:12];
    assign full_len = wide_mode ? LEN128 : LEN64;

    always_comb begin
        ctrl.legal   = 1'b0;
        ctrl.kind    = K_ADD;
        ctrl.len     = full_len;
        ctrl.use_imm = 1'b0;
        ctrl.imm     = instr[31:20];
        ctrl.rd      = instr[11:7];
        case (opc)
            OPC_REG: begin
                if (f7 == F7_BASE) begin
                    case (f3)
                        F3_ADD:  begin ctrl.legal = 1'b1; ctrl.kind = K_ADD;  end
                        F3_SLT:  begin ctrl.legal = 1'b1; ctrl.kind = K_SLT;  end
                        F3_SLTU: begin ctrl.legal = 1'b1; ctrl.kind = K_SLTU; end
                        default: ctrl.legal = 1'b0;
                    endcase
                end else if (f7 == F7_ALT && f3 == F3_ADD) begin
                    ctrl.legal = 1'b1;
                    ctrl.kind  = K_SUB;
                end
            end
            OPC_IMM: begin
                ctrl.use_imm = 1'b1;
                case (f3)
                    F3_ADD:  begin ctrl.legal = 1'b1; ctrl.kind = K_ADD;  end
                    F3_SLT:  begin ctrl.legal = 1'b1; ctrl.kind = K_SLT;  end
                    F3_SLTU: begin ctrl.legal = 1'b1; ctrl.kind = K_SLTU; end
                    default: ctrl.legal = 1'b0;
                endcase
            end
            OPC_REG_W, OPC_REG_D: begin
                ctrl.len = (opc == OPC_REG_W) ? LEN32 : LEN64;
                if (f3 == F3_ADD && (f7 == F7_BASE || f7 == F7_ALT)) begin
                    ctrl.legal = (opc == OPC_REG_W) || wide_mode;
                    ctrl.kind  = (f7 == F7_ALT) ? K_SUB : K_ADD;
                end
            end
            OPC_IMM_W, OPC_IMM_D: begin
                ctrl.len     = (opc == OPC_IMM_W) ? LEN32 : LEN64;
                ctrl.use_imm = 1'b1;
                if (f3 == F3_ADD) begin
                    ctrl.legal = (opc == OPC_IMM_W) || wide_mode;
                end
            end
            default: ctrl.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/rv_wide_add_slice.sv
module rv_wide_add_slice #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] total;

    assign total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    assign sum   = total[W-1:0];
    assign cout  = total[W];

endmodule

// File: rtl/rv_wide_alu.sv
module rv_wide_alu
    import rv_wide_pkg::*;
(
    input  exec_ctrl_t        ctrl,
    input  logic [FULL_W-1:0] opa,
    input  logic [FULL_W-1:0] opb_reg,
    output logic [FULL_W-1:0] result
);

    logic [FULL_W-1:0]   opb;
    logic [FULL_W-1:0]   opb_eff;
    logic [FULL_W-1:0]   sum;
    logic [N_HALVES:0]   carry;
    logic                invert;

    assign opb     = ctrl.use_imm ? widen_imm(ctrl.imm) : opb_reg;
    assign invert  = (ctrl.kind != K_ADD);
    assign opb_eff = invert ? ~opb : opb;
    assign carry[0] = invert;

    for (genvar h = 0; h < N_HALVES; h++) begin : g_slice
        rv_wide_add_slice #(.W(HALF_W)) i_slice (
            .a   (opa[h*HALF_W +: HALF_W]),
            .b   (opb_eff[h*HALF_W +: HALF_W]),
            .cin (carry[h]),
            .sum (sum[h*HALF_W +: HALF_W]),
            .cout(carry[h+1])
        );
    end

    logic a_sign;
    logic b_sign;
    logic d_sign;
    logic no_borrow;
    logic less_s;
    logic less_u;

    always_comb begin
        if (ctrl.len == LEN128) begin
            a_sign    = opa[FULL_W-1];
            b_sign    = opb[FULL_W-1];
            d_sign    = sum[FULL_W-1];
            no_borrow = carry[N_HALVES];
        end else begin
            a_sign    = opa[HALF_W-1];
            b_sign    = opb[HALF_W-1];
            d_sign    = sum[HALF_W-1];
            no_borrow = carry[1];
        end
        less_u = ~no_borrow;
        less_s = (a_sign ^ b_sign) ? a_sign : d_sign;
    end

    always_comb begin
        case (ctrl.kind)
            K_SLT:   result = {{(FULL_W-1){1'b0}}, less_s};
            K_SLTU:  result = {{(FULL_W-1){1'b0}}, less_u};
            default: result = fit_length(sum, ctrl.len);
        endcase
    end

endmodule

// File: rtl/rv_wide_addsub_unit.sv
module rv_wide_addsub_unit
    import rv_wide_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic                 wide_mode,
    input  logic [HALF_W-1:0]    src1_lo,
    input  logic [HALF_W-1:0]    src1_hi,
    input  logic [HALF_W-1:0]    src2_lo,
    input  logic [HALF_W-1:0]    src2_hi,
    output logic                 res_valid,
    output logic [FULL_W-1:0]    res_data,
    output logic [REG_IDX_W-1:0] res_rd,
    output logic                 res_we,
    output logic                 res_illegal
);

    exec_ctrl_t        ctrl;
    logic [FULL_W-1:0] alu_out;

    rv_wide_decode i_decode (
        .instr    (instr),
        .wide_mode(wide_mode),
        .ctrl     (ctrl)
    );

    rv_wide_alu i_alu (
        .ctrl   (ctrl),
        .opa    ({src1_hi, src1_lo}),
        .opb_reg({src2_hi, src2_lo}),
        .result (alu_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_we      <= 1'b0;
            res_illegal <= 1'b0;
            res_data    <= '0;
            res_rd      <= '0;
        end else begin
            res_valid   <= in_valid;
            res_illegal <= in_valid & ~ctrl.legal;
            res_we      <= in_valid & ctrl.legal & (ctrl.rd != '0);
            if (in_valid) begin
                res_data <= ctrl.legal ? alu_out : '0;
                res_rd   <= ctrl.rd;
            end
        end
    end

endmodule

// File: rtl/rv_wide_addsub_checks.sv
module rv_wide_addsub_checks
    import rv_wide_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [INSTR_W-1:0]   instr,
    input logic                 wide_mode,
    input logic                 res_valid,
    input logic [FULL_W-1:0]    res_data,
    input logic [REG_IDX_W-1:0] res_rd,
    input logic                 res_we,
    input logic                 res_illegal
);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);

    assert_illegal_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        res_illegal |-> (!res_we && res_data == '0));

    assert_no_x0_write_R10: assert property (@(posedge clk) disable iff (rst)
        res_we |-> (res_rd != '0));

    assert_word_sext_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_illegal &&
         ($past(instr[6:0]) == OPC_REG_W || $past(instr[6:0]) == OPC_IMM_W))
        |-> (res_data[FULL_W-1:WORD_W] == {(FULL_W-WORD_W){res_data[WORD_W-1]}}));

    assert_cmp_one_bit_R5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_illegal && $past(instr[13]) &&
         ($past(instr[6:0]) == OPC_REG || $past(instr[6:0]) == OPC_IMM))
        |-> (res_data[FULL_W-1:1] == '0));

    assert_dlen_refused_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !$past(wide_mode) &&
         ($past(instr[6:0]) == OPC_REG_D || $past(instr[6:0]) == OPC_IMM_D))
        |-> res_illegal);

endmodule

bind rv_wide_addsub_unit rv_wide_addsub_checks i_checks (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .instr      (instr),
    .wide_mode  (wide_mode),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .res_rd     (res_rd),
    .res_we     (res_we),
    .res_illegal(res_illegal)
);

// File: tb/test_rv_wide_addsub_unit.sv
`timescale 1ns/1ps
module test_rv_wide_addsub_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [31:0]  instr;
    logic         wide_mode;
    logic [63:0]  src1_lo, src1_hi, src2_lo, src2_hi;
    logic         res_valid;
    logic [127:0] res_data;
    logic [4:0]   res_rd;
    logic         res_we;
    logic         res_illegal;

    int total = 0;
    int bad   = 0;

    localparam logic [63:0]  ONES64  = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [127:0] ONES128 = {ONES64, ONES64};

    always #2.5 clk = ~clk;

    rv_wide_addsub_unit i_rv_wide_addsub_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .wide_mode(wide_mode),
        .src1_lo(src1_lo), .src1_hi(src1_hi), .src2_lo(src2_lo), .src2_hi(src2_hi),
        .res_valid(res_valid), .res_data(res_data), .res_rd(res_rd),
        .res_we(res_we), .res_illegal(res_illegal)
    );

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [2:0] f3,
                                          input logic [4:0] rd, input logic [6:0] opc);
        return {f7, 5'd2, 5'd1, f3, rd, opc};
    endfunction

    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [2:0] f3,
                                          input logic [4:0] rd, input logic [6:0] opc);
        return {imm, 5'd1, f3, rd, opc};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] ins, input logic [127:0] a,
                         input logic [127:0] b, input logic wide);
        @(negedge clk);
        in_valid  = 1'b1;
        instr     = ins;
        wide_mode = wide;
        {src1_hi, src1_lo} = a;
        {src2_hi, src2_lo} = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b1; instr = enc_r(7'h00, 3'b000, 5'd3, 7'b0110011);
        wide_mode = 1'b1; src1_lo = 1; src1_hi = 0; src2_lo = 1; src2_hi = 0;
        repeat (3) @(negedge clk);
        chk("R1 valid", {127'd0, res_valid}, 128'd0);
        chk("R1 we", {127'd0, res_we}, 128'd0);
        chk("R1 illegal", {127'd0, res_illegal}, 128'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R2 idle", {127'd0, res_valid}, 128'd0);
    endtask

    task automatic t_full_add_sub;
        issue(enc_r(7'h00, 3'b000, 5'd7, 7'b0110011), {64'd0, ONES64}, 128'd1, 1'b1);
        chk("R3 add carry", res_data, {64'd1, 64'd0});
        chk("R2 valid", {127'd0, res_valid}, 128'd1);
        chk("R2 rd", {123'd0, res_rd}, 128'd7);
        chk("R10 we", {127'd0, res_we}, 128'd1);
        issue(enc_r(7'h20, 3'b000, 5'd7, 7'b0110011), {64'd1, 64'd0}, 128'd1, 1'b1);
        chk("R3 sub borrow", res_data, {64'd0, ONES64});
    endtask

    task automatic t_add_imm;
        issue(enc_i(12'hFFF, 3'b000, 5'd4, 7'b0010011), 128'd0, 128'd0, 1'b1);
        chk("R4 negative imm", res_data, ONES128);
        issue(enc_i(12'h005, 3'b000, 5'd4, 7'b0010011), ONES128, 128'd0, 1'b1);
        chk("R4 wrap", res_data, 128'd4);
    endtask

    task automatic t_compare;
        issue(enc_r(7'h00, 3'b010, 5'd5, 7'b0110011), ONES128, 128'd1, 1'b1);
        chk("R5 slt neg", res_data, 128'd1);
        issue(enc_r(7'h00, 3'b011, 5'd5, 7'b0110011), ONES128, 128'd1, 1'b1);
        chk("R5 sltu big", res_data, 128'd0);
        issue(enc_r(7'h00, 3'b011, 5'd5, 7'b0110011), {64'd0, 64'd5}, {64'd1, 64'd0}, 1'b1);
        chk("R5 sltu high half", res_data, 128'd1);
        issue(enc_r(7'h00, 3'b010, 5'd5, 7'b0110011), {64'd1, 64'd0}, {64'd0, ONES64}, 1'b1);
        chk("R5 slt high half", res_data, 128'd0);
        issue(enc_i(12'hFFF, 3'b010, 5'd5, 7'b0010011), ONES128 - 128'd1, 128'd0, 1'b1);
        chk("R5 slti", res_data, 128'd1);
        issue(enc_i(12'hFFF, 3'b011, 5'd5, 7'b0010011), 128'd5, 128'd0, 1'b1);
        chk("R5 sltiu", res_data, 128'd1);
    endtask

    task automatic t_word;
        issue(enc_r(7'h00, 3'b000, 5'd6, 7'b0111011), {64'hDEAD, 64'hAAAA_0000_7FFF_FFFF},
              {64'h1234, 64'h5555_0000_0000_0001}, 1'b1);
        chk("R6 addw sext", res_data, {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'h8000_0000});
        issue(enc_r(7'h20, 3'b000, 5'd6, 7'b0111011), 128'd0, 128'd1, 1'b1);
        chk("R6 subw", res_data, ONES128);
        issue(enc_i(12'h003, 3'b000, 5'd6, 7'b0011011), {64'hBEEF, 64'h0000_0001_0000_0005},
              128'd0, 1'b0);
        chk("R6 addiw narrow mode", res_data, 128'd8);
        chk("R6 legal narrow", {127'd0, res_illegal}, 128'd0);
    endtask

    task automatic t_dlen;
        issue(enc_r(7'h00, 3'b000, 5'd8, 7'b1111011), {64'h77, 64'h7FFF_FFFF_FFFF_FFFF},
              {64'h99, 64'd1}, 1'b1);
        chk("R7 64-len add", res_data, {ONES64, 64'h8000_0000_0000_0000});
        issue(enc_r(7'h20, 3'b000, 5'd8, 7'b1111011), {64'h5, 64'd3}, {64'h0, 64'd1}, 1'b1);
        chk("R7 64-len sub", res_data, 128'd2);
        issue(enc_i(12'hFFE, 3'b000, 5'd8, 7'b1011011), {64'h1, 64'd1}, 128'd0, 1'b1);
        chk("R7 64-len addi", res_data, ONES128);
        issue(enc_r(7'h00, 3'b000, 5'd8, 7'b1111011), 128'd1, 128'd1, 1'b0);
        chk("R7 refused narrow", {127'd0, res_illegal}, 128'd1);
        chk("R9 refused no write", {127'd0, res_we}, 128'd0);
    endtask

    task automatic t_narrow;
        issue(enc_r(7'h00, 3'b000, 5'd9, 7'b0110011), {64'd0, ONES64}, 128'd1, 1'b0);
        chk("R8 add no carry out", res_data, 128'd0);
        issue(enc_r(7'h00, 3'b010, 5'd9, 7'b0110011), {64'd5, 64'd1}, {64'd0, 64'd2}, 1'b0);
        chk("R8 slt low halves", res_data, 128'd1);
        issue(enc_r(7'h00, 3'b010, 5'd9, 7'b0110011), {64'd5, 64'd1}, {64'd0, 64'd2}, 1'b1);
        chk("R5 slt wide same operands", res_data, 128'd0);
    endtask

    task automatic t_illegal;
        issue(enc_r(7'h00, 3'b001, 5'd10, 7'b0110011), 128'd3, 128'd4, 1'b1);
        chk("R9 illegal flag", {127'd0, res_illegal}, 128'd1);
        chk("R9 illegal data", res_data, 128'd0);
        chk("R9 illegal we", {127'd0, res_we}, 128'd0);
        issue(enc_r(7'h20, 3'b010, 5'd10, 7'b0110011), 128'd3, 128'd4, 1'b1);
        chk("R9 alt funct7 compare", {127'd0, res_illegal}, 128'd1);
    endtask

    task automatic t_x0;
        issue(enc_r(7'h00, 3'b000, 5'd0, 7'b0110011), 128'd3, 128'd4, 1'b1);
        chk("R10 x0 we", {127'd0, res_we}, 128'd0);
        chk("R10 x0 valid", {127'd0, res_valid}, 128'd1);
        @(negedge clk);
        chk("R2 drop valid", {127'd0, res_valid}, 128'd0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_full_add_sub();
                t_add_imm();
                t_compare();
                t_word();
                t_dlen();
                t_narrow();
                t_illegal();
                t_x0();
            end
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule